// File: doc/BRIEF.md
# Checked Integer Arithmetic Unit

This block is the arithmetic part of the execute stage in a small RISC core. It adds, subtracts or compares two 32-bit words in a single combinational pass. A two-bit operation code selects the function. A separate qualifier decides whether signed overflow may raise an exception flag.

Operands that come from immediates arrive already extended and are handled exactly like register operands. Subtracting a constant is therefore an add with the negated constant. In the checking form, overflow raises a one-bit flag and the wrapped value still appears on the result. The surrounding core decides whether to suppress the register write and trap. In the wrapping form, the flag never rises.

The compare operation produces the word 1 or 0 from a signed comparison. That comparison stays correct even when the internal difference overflows.

Top module: `int_alu`

## Requirements
- R1: With op_i = 2'b00 (add), result_o equals (a_i + b_i) modulo 2^32.
- R2: With op_i = 2'b01 (subtract), result_o equals (a_i - b_i) modulo 2^32.
- R3: With op_i = 2'b00 and trap_en_i = 1, ovf_o is 1 exactly when the two's-complement sum of a_i and b_i lies outside [-2^31, 2^31-1].
- R4: With op_i = 2'b01 and trap_en_i = 1, ovf_o is 1 exactly when the two's-complement difference a_i - b_i lies outside [-2^31, 2^31-1].
- R5: With trap_en_i = 0, ovf_o stays 0 for every operation, and result_o is identical to the result of the same operands with trap_en_i = 1.
- R6: With op_i = 2'b10 (set-less-than), result_o is 32'd1 when a_i is less than b_i as signed numbers and 32'd0 otherwise, including operand pairs whose difference overflows.
- R7: With op_i = 2'b10, ovf_o stays 0 whatever trap_en_i is.
- R8: When ovf_o is 1, result_o still carries the wrapped 32-bit sum or difference.
- R9: With op_i = 2'b11 (reserved), result_o is 0 and ovf_o is 0.
- R10: The block holds no state: result_o and ovf_o follow the inputs within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, register value or extended immediate |
| op_i | input | 2 | Function: 00 add, 01 subtract, 10 set-less-than, 11 reserved |
| trap_en_i | input | 1 | 1 selects the overflow-checking form, 0 the wrapping form |
| result_o | output | 32 | Arithmetic result |
| ovf_o | output | 1 | Overflow exception indication |

## Verification
Both outputs depend only on the current inputs, so every result is due in the same cycle as its stimulus. The bench changes the inputs just after a rising edge and compares the outputs at the following falling edge, half a period later. No register lies between input and output, so no extra cycle is counted. Each operation is checked against a reference that uses 33-bit signed arithmetic. The operand pairs are all combinations of the sign-boundary values plus random words.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_SLT = 2'b10,
    OP_RSV = 2'b11
  } alu_op_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_raw_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  // subtract as a + ~b + 1
  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o = full[W-1:0];

  // like-signed inputs giving an opposite-signed output
  assign ovf_raw_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/int_alu_ovf_gate.sv
module int_alu_ovf_gate
  import int_alu_pkg::*;
(
  input  alu_op_e op_i,
  input  logic    trap_en_i,
  input  logic    ovf_raw_i,
  output logic    ovf_o
);
  logic arith_op;

  assign arith_op = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign ovf_o    = arith_op && trap_en_i && ovf_raw_i;
endmodule

// File: rtl/int_alu_slt.sv
module int_alu_slt #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] diff_i,
  input  logic         ovf_raw_i,
  output logic [W-1:0] flag_word_o
);
  logic less;

  // overflow flips the apparent sign of the difference
  assign less        = diff_i[W-1] ^ ovf_raw_i;
  assign flag_word_o = {{(W-1){1'b0}}, less};
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
(
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic [1:0]  op_i,
  input  logic        trap_en_i,
  output logic [31:0] result_o,
  output logic        ovf_o
);
  localparam int unsigned W = DATA_W;

  alu_op_e      op;
  logic         do_sub;
  logic [W-1:0] sum;
  logic         ovf_raw;
  logic [W-1:0] slt_word;

  assign op     = alu_op_e'(op_i);
  assign do_sub = (op == OP_SUB) || (op == OP_SLT);

  int_alu_addsub #(.W(W)) u_addsub (
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_i    (do_sub),
    .sum_o    (sum),
    .ovf_raw_o(ovf_raw)
  );

  int_alu_slt #(.W(W)) u_slt (
    .diff_i     (sum),
    .ovf_raw_i  (ovf_raw),
    .flag_word_o(slt_word)
  );

  int_alu_ovf_gate u_gate (
    .op_i     (op),
    .trap_en_i(trap_en_i),
    .ovf_raw_i(ovf_raw),
    .ovf_o    (ovf_o)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result_o = sum;
      OP_SLT:         result_o = slt_word;
      default:        result_o = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk (
  input logic [31:0] a_i,
  input logic [31:0] b_i,
  input logic [1:0]  op_i,
  input logic        trap_en_i,
  input logic [31:0] result_o,
  input logic        ovf_o
);
  logic signed [32:0] wide_sum;
  logic signed [32:0] wide_dif;
  logic               known;

  assign wide_sum = $signed({a_i[31], a_i}) + $signed({b_i[31], b_i});
  assign wide_dif = $signed({a_i[31], a_i}) - $signed({b_i[31], b_i});
  assign known    = !$isunknown({a_i, b_i, op_i, trap_en_i});

  always_comb begin
    if (known) begin
      // R1
      add_wrap_chk: assert (op_i != 2'b00 || result_o == wide_sum[31:0]);
      // R2
      sub_wrap_chk: assert (op_i != 2'b01 || result_o == wide_dif[31:0]);
      // R3
      add_ovf_chk: assert (!(op_i == 2'b00 && trap_en_i) ||
                           ovf_o == (wide_sum[32] != wide_sum[31]));
      // R4
      sub_ovf_chk: assert (!(op_i == 2'b01 && trap_en_i) ||
                           ovf_o == (wide_dif[32] != wide_dif[31]));
      // R5
      no_overflow_chk: assert (trap_en_i || !ovf_o);
      // R6
      slt_word_chk: assert (op_i != 2'b10 ||
                            result_o == {31'd0, wide_dif[32]});
      // R7
      slt_quiet_chk: assert (op_i != 2'b10 || !ovf_o);
      // R9
      rsv_zero_chk: assert (op_i != 2'b11 || (result_o == '0 && !ovf_o));
    end
  end
endmodule

bind int_alu int_alu_chk u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .trap_en_i(trap_en_i),
  .result_o (result_o),
  .ovf_o    (ovf_o)
);

// File: tb/int_alu_test.sv
module int_alu_test;
  logic        clk = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [1:0]  op_i = 2'b00;
  logic        trap_en_i = 1'b0;
  logic [31:0] result_o;
  logic        ovf_o;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  logic [31:0] corners [4];

  always #5 clk = ~clk;

  int_alu uut (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .trap_en_i(trap_en_i),
    .result_o (result_o),
    .ovf_o    (ovf_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL R10 watchdog expired: cycle %0d expected below 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [1:0] op, input logic chk,
                                output logic [31:0] res, output logic ovf);
    logic signed [32:0] w;
    res = '0;
    ovf = 1'b0;
    case (op)
      2'b00: begin
        w = $signed({a[31], a}) + $signed({b[31], b});
        res = w[31:0];
        ovf = chk && (w[32] != w[31]);
      end
      2'b01: begin
        w = $signed({a[31], a}) - $signed({b[31], b});
        res = w[31:0];
        ovf = chk && (w[32] != w[31]);
      end
      2'b10: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: ;
    endcase
  endfunction

  // inputs change after a rising edge, outputs compared at the falling edge
  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] op, input logic chk, input string req);
    logic [31:0] er;
    logic        eo;
    @(posedge clk);
    #1;
    a_i = a; b_i = b; op_i = op; trap_en_i = chk;
    model(a, b, op, chk, er, eo);
    @(negedge clk);
    checks = checks + 1;
    if (result_o !== er || ovf_o !== eo) begin
      errors = errors + 1;
      $display("FAIL %s a=%h b=%h op=%0d chk=%0d: got %h/%0b expected %h/%0b",
               req, a, b, op, chk, result_o, ovf_o, er, eo);
    end
  endtask

  task automatic idle_state;
    // R10: all-zero inputs give a zero result at once
    apply(32'd0, 32'd0, 2'b00, 1'b0, "R10");
  endtask

  task automatic add_cases;
    apply(32'd5, 32'd7, 2'b00, 1'b1, "R1");
    apply(32'h0000_0020, 32'hFFFF_FFF6, 2'b00, 1'b1, "R1");  // add -10
    apply(32'h7FFF_FFFF, 32'd1, 2'b00, 1'b1, "R3 R8");
    apply(32'h8000_0000, 32'hFFFF_FFFF, 2'b00, 1'b1, "R3 R8");
    apply(32'h7FFF_FFFF, 32'h8000_0000, 2'b00, 1'b1, "R3");
  endtask

  task automatic sub_cases;
    apply(32'd3, 32'd10, 2'b01, 1'b1, "R2");
    apply(32'h8000_0000, 32'd1, 2'b01, 1'b1, "R4 R8");
    apply(32'd0, 32'h8000_0000, 2'b01, 1'b1, "R4");
    apply(32'hFFFF_FFFF, 32'h8000_0000, 2'b01, 1'b1, "R4");
  endtask

  task automatic wrap_cases;
    apply(32'h7FFF_FFFF, 32'd1, 2'b00, 1'b0, "R5");
    apply(32'h8000_0000, 32'd1, 2'b01, 1'b0, "R5");
  endtask

  task automatic slt_cases;
    apply(32'hFFFF_FFFF, 32'd0, 2'b10, 1'b1, "R6");
    apply(32'd0, 32'hFFFF_FFFF, 2'b10, 1'b0, "R6");
    apply(32'h8000_0000, 32'h7FFF_FFFF, 2'b10, 1'b1, "R6 R7");
    apply(32'h7FFF_FFFF, 32'h8000_0000, 2'b10, 1'b1, "R6 R7");
    apply(32'd9, 32'd9, 2'b10, 1'b1, "R6");
  endtask

  task automatic reserved_cases;
    apply(32'h7FFF_FFFF, 32'd1, 2'b11, 1'b1, "R9");
    apply(32'h1234_5678, 32'h8000_0000, 2'b11, 1'b0, "R9");
  endtask

  task automatic corner_sweep;
    corners[0] = 32'h7FFF_FFFF; corners[1] = 32'h8000_0000;
    corners[2] = 32'd0;         corners[3] = 32'hFFFF_FFFF;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int op = 0; op < 4; op++)
          for (int c = 0; c < 2; c++)
            apply(corners[i], corners[j], op[1:0], c[0], "R1 R2 R3 R4 R5 R6 R7 R9");
  endtask

  task automatic random_sweep;
    for (int k = 0; k < 400; k++)
      apply($urandom, $urandom, k[1:0], k[2], "R1 R2 R3 R4 R5 R6 R7 R9");
  endtask

  initial begin
    idle_state();
    add_cases();
    sub_cases();
    wrap_cases();
    slt_cases();
    reserved_cases();
    corner_sweep();
    random_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule